// File: doc/BRIEF.md
# Ring Entropy Source Tuning Controller

This controller searches for a usable setting of a configurable ring-based entropy source and then keeps watch over it. For each attempt it takes a fresh word from an internal shift-register generator and drives it out as the per-stage delay-cell select bits. It then gathers a batch of collapse counts reported by the source and computes two statistics: the batch sum, which stands for the mean, and the batch maximum. A setting is accepted only when both statistics fall inside programmable windows.

The mean test avoids a divider. The batch sum is compared against the window bounds multiplied by the batch length. Once a setting is accepted, the controller asserts ready and opens the gate for harvested bits. It keeps judging every following batch. A failing batch closes the gate, raises an alert (an out-of-range statistic may point to an injection-locking attack on the supply) and restarts the search. A programmable trial budget bounds each search. When the budget runs out, the controller freezes with the alert raised until reset.

Top module: `entropy_tune_ctrl`

## Requirements
- R1: While reset is high and on the cycle after it, `ready_o`, `alert_o` and `bits_valid_o` are 0, `trial_cnt_o` is 0 and `cfg_o` is 0. The first trial after reset drives `cfg_o` to the seed `96'h5A5A_0000_0000_0000_0000_ACE1` and sets `trial_cnt_o` to 1.
- R2: Trial words come from a 96-bit Fibonacci generator. The feedback bit is the XOR of state bits 95, 93, 48 and 46. The state shifts toward the MSB and the feedback enters bit 0. Each trial drives the current state to `cfg_o`, with stage i selected by bits [3i+2:3i], and then steps the generator exactly once. `trial_cnt_o` rises by one per trial.
- R3: A count is taken only while a batch is being collected and `cnt_valid_i` is 1. After `batch_len_i` counts the batch is judged.
- R4: The mean passes when `mean_lo_i*N <= sum <= mean_hi_i*N`, where N is `batch_len_i`; both bounds are inclusive. During a search, a mean below the window rejects the trial and starts the next one without changing `alert_o`. The maximum is not consulted in that case.
- R5: When the mean is not below the window, the maximum must lie within `[max_lo_i, max_hi_i]` inclusive. A maximum outside that range rejects the trial and sets `alert_o`.
- R6: A mean above the window rejects the trial and sets `alert_o`.
- R7: A batch that passes both tests sets `ready_o`, clears `alert_o`, and leaves `cfg_o` and `trial_cnt_o` unchanged.
- R8: While ready, every batch is judged again. A passing batch keeps ready. A failing batch of any kind clears `ready_o`, sets `alert_o`, resets the trial count, and starts a new trial (`trial_cnt_o` becomes 1 with the next generator word).
- R9: `bits_valid_o` is 1 exactly when `ready_o` and `cnt_valid_i` are both 1.
- R10: When the trial that brings `trial_cnt_o` up to `trial_limit_i` is rejected, the controller locks out. `alert_o` stays 1, `cfg_o` and `trial_cnt_o` freeze, and later batches have no effect until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cnt_valid_i | input | 1 | A collapse count is present |
| cnt_i | input | 9 | Collapse count from the source |
| batch_len_i | input | 13 | Counts per batch (N) |
| mean_lo_i | input | 9 | Lower bound of mean window |
| mean_hi_i | input | 9 | Upper bound of mean window |
| max_lo_i | input | 9 | Lower bound of maximum window |
| max_hi_i | input | 9 | Upper bound of maximum window |
| trial_limit_i | input | 10 | Trials allowed per search |
| cfg_o | output | 96 | Delay-cell select word, 3 bits per stage |
| ready_o | output | 1 | Source tuned and accepted |
| bits_valid_o | output | 1 | Gate for harvested bits |
| alert_o | output | 1 | Statistic out of range or search exhausted |
| trial_cnt_o | output | 10 | Trials in the current search |

## Verification
Batches are sent with means below, exactly on, and just above the window edges, so the inclusive bounds of R4 and R6 are tested from both sides. One batch has a low mean together with a bad maximum; it shows that the mean is checked first and that no alert is raised for it. Another batch has a good mean with a single large count; it isolates the maximum test. While the controller is locked, batches that keep the lock are mixed with batches that break it, to exercise monitoring and the restart. A final run of low batches uses up the trial budget and then shows that further input changes nothing.

// File: rtl/etc_pkg.sv
package etc_pkg;

    localparam int STAGES_DEF  = 32;
    localparam int SEL_W_DEF   = 3;
    localparam int CFG_W_DEF   = STAGES_DEF * SEL_W_DEF;
    localparam int CNT_W_DEF   = 9;
    localparam int BATCH_W_DEF = 13;
    localparam int TRIAL_W_DEF = 10;

    localparam logic [CFG_W_DEF-1:0] LFSR_TAPS_DEF =
        (96'b1 << 95) | (96'b1 << 93) | (96'b1 << 48) | (96'b1 << 46);
    localparam logic [CFG_W_DEF-1:0] LFSR_SEED_DEF = 96'h5A5A_0000_0000_0000_0000_ACE1;

    typedef enum logic [1:0] {
        ST_LOAD    = 2'd0,
        ST_COLLECT = 2'd1,
        ST_LOCKOUT = 2'd2
    } tune_state_e;

    typedef struct packed {
        logic mean_low;
        logic mean_high;
        logic max_bad;
    } verdict_t;

    function automatic logic verdict_pass(verdict_t v);
        return !(v.mean_low || v.mean_high || v.max_bad);
    endfunction

    function automatic logic verdict_alarm(verdict_t v);
        return v.mean_high || (!v.mean_low && v.max_bad);
    endfunction

endpackage

// File: rtl/etc_lfsr.sv
module etc_lfsr #(
    parameter int          W    = 96,
    parameter logic [W-1:0] TAPS = '1,
    parameter logic [W-1:0] SEED = '1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         step,
    output logic [W-1:0] state_o
);

    logic [W-1:0] state_q;
    logic         fb;

    assign fb      = ^(state_q & TAPS);
    assign state_o = state_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SEED;
        end else if (step) begin
            state_q <= {state_q[W-2:0], fb};
        end
    end

    AST_LFSR_NONZERO: assert property (@(posedge clk) disable iff (rst)
        state_q != '0); // R2

    AST_LFSR_HOLD: assert property (@(posedge clk) disable iff (rst)
        !step |=> $stable(state_q)); // R2

endmodule

// File: rtl/etc_batch_stats.sv
module etc_batch_stats #(
    parameter int CNT_W   = 9,
    parameter int BATCH_W = 13,
    parameter int SUM_W   = CNT_W + BATCH_W
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               clear,
    input  logic               sample_en,
    input  logic [CNT_W-1:0]   sample,
    input  logic [BATCH_W-1:0] batch_len,
    output logic [SUM_W-1:0]   sum_o,
    output logic [CNT_W-1:0]   max_o,
    output logic               full_o
);

    logic [BATCH_W-1:0] n_q;
    logic [BATCH_W-1:0] n_next;

    assign n_next = n_q + 1'b1;

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            sum_o  <= '0;
            max_o  <= '0;
            n_q    <= '0;
            full_o <= 1'b0;
        end else if (sample_en) begin
            sum_o <= sum_o + SUM_W'(sample);
            if (sample > max_o) begin
                max_o <= sample;
            end
            n_q <= n_next;
            if (n_next == batch_len) begin
                full_o <= 1'b1;
            end
        end
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        (sample_en && !clear) |=> sum_o >= $past(sum_o)); // R3

    AST_MAX_TRACK: assert property (@(posedge clk) disable iff (rst)
        (sample_en && !clear) |=> max_o >= $past(sample)); // R3

endmodule

// File: rtl/etc_window_check.sv
module etc_window_check
    import etc_pkg::*;
#(
    parameter int CNT_W   = 9,
    parameter int BATCH_W = 13,
    parameter int SUM_W   = CNT_W + BATCH_W
) (
    input  logic [SUM_W-1:0]   sum,
    input  logic [CNT_W-1:0]   max_val,
    input  logic [BATCH_W-1:0] batch_len,
    input  logic [CNT_W-1:0]   mean_lo,
    input  logic [CNT_W-1:0]   mean_hi,
    input  logic [CNT_W-1:0]   max_lo,
    input  logic [CNT_W-1:0]   max_hi,
    output verdict_t           verdict_o
);

    logic [SUM_W-1:0] lo_scaled;
    logic [SUM_W-1:0] hi_scaled;

    always_comb begin
        lo_scaled           = SUM_W'(mean_lo) * SUM_W'(batch_len);
        hi_scaled           = SUM_W'(mean_hi) * SUM_W'(batch_len);
        verdict_o.mean_low  = sum < lo_scaled;
        verdict_o.mean_high = sum > hi_scaled;
        verdict_o.max_bad   = (max_val < max_lo) || (max_val > max_hi);
    end

endmodule

// File: rtl/entropy_tune_ctrl.sv
module entropy_tune_ctrl
    import etc_pkg::*;
#(
    parameter int STAGES  = STAGES_DEF,
    parameter int SEL_W   = SEL_W_DEF,
    parameter int CNT_W   = CNT_W_DEF,
    parameter int BATCH_W = BATCH_W_DEF,
    parameter int TRIAL_W = TRIAL_W_DEF,
    parameter logic [STAGES*SEL_W-1:0] TAPS = LFSR_TAPS_DEF,
    parameter logic [STAGES*SEL_W-1:0] SEED = LFSR_SEED_DEF
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      cnt_valid_i,
    input  logic [CNT_W-1:0]          cnt_i,
    input  logic [BATCH_W-1:0]        batch_len_i,
    input  logic [CNT_W-1:0]          mean_lo_i,
    input  logic [CNT_W-1:0]          mean_hi_i,
    input  logic [CNT_W-1:0]          max_lo_i,
    input  logic [CNT_W-1:0]          max_hi_i,
    input  logic [TRIAL_W-1:0]        trial_limit_i,
    output logic [STAGES*SEL_W-1:0]   cfg_o,
    output logic                      ready_o,
    output logic                      bits_valid_o,
    output logic                      alert_o,
    output logic [TRIAL_W-1:0]        trial_cnt_o
);

    localparam int CFG_W = STAGES * SEL_W;
    localparam int SUM_W = CNT_W + BATCH_W;

    tune_state_e      state_q;
    logic [CFG_W-1:0] lfsr_word;
    logic             lfsr_step;
    logic             stats_clear;
    logic             sample_en;
    logic             batch_full;
    logic [SUM_W-1:0] batch_sum;
    logic [CNT_W-1:0] batch_max;
    verdict_t         verdict;
    logic             budget_left;

    assign budget_left  = trial_cnt_o < trial_limit_i;
    assign lfsr_step    = (state_q == ST_LOAD) && budget_left;
    assign sample_en    = (state_q == ST_COLLECT) && cnt_valid_i && !batch_full;
    assign stats_clear  = (state_q == ST_LOAD) || ((state_q == ST_COLLECT) && batch_full);
    assign bits_valid_o = ready_o && cnt_valid_i;

    etc_lfsr #(
        .W    (CFG_W),
        .TAPS (TAPS),
        .SEED (SEED)
    ) lfsr_i (
        .clk     (clk),
        .rst     (rst),
        .step    (lfsr_step),
        .state_o (lfsr_word)
    );

    etc_batch_stats #(
        .CNT_W   (CNT_W),
        .BATCH_W (BATCH_W),
        .SUM_W   (SUM_W)
    ) stats_i (
        .clk       (clk),
        .rst       (rst),
        .clear     (stats_clear),
        .sample_en (sample_en),
        .sample    (cnt_i),
        .batch_len (batch_len_i),
        .sum_o     (batch_sum),
        .max_o     (batch_max),
        .full_o    (batch_full)
    );

    etc_window_check #(
        .CNT_W   (CNT_W),
        .BATCH_W (BATCH_W),
        .SUM_W   (SUM_W)
    ) window_i (
        .sum       (batch_sum),
        .max_val   (batch_max),
        .batch_len (batch_len_i),
        .mean_lo   (mean_lo_i),
        .mean_hi   (mean_hi_i),
        .max_lo    (max_lo_i),
        .max_hi    (max_hi_i),
        .verdict_o (verdict)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q     <= ST_LOAD;
            cfg_o       <= '0;
            trial_cnt_o <= '0;
            ready_o     <= 1'b0;
            alert_o     <= 1'b0;
        end else begin
            case (state_q)
                ST_LOAD: begin
                    if (!budget_left) begin
                        state_q <= ST_LOCKOUT;
                        alert_o <= 1'b1;
                    end else begin
                        cfg_o       <= lfsr_word;
                        trial_cnt_o <= trial_cnt_o + 1'b1;
                        state_q     <= ST_COLLECT;
                    end
                end
                ST_COLLECT: begin
                    if (batch_full) begin
                        if (verdict_pass(verdict)) begin
                            ready_o <= 1'b1;
                            alert_o <= 1'b0;
                        end else begin
                            state_q <= ST_LOAD;
                            ready_o <= 1'b0;
                            if (ready_o) begin
                                alert_o     <= 1'b1;
                                trial_cnt_o <= '0;
                            end else if (verdict_alarm(verdict)) begin
                                alert_o <= 1'b1;
                            end
                        end
                    end
                end
                default: begin
                    state_q <= ST_LOCKOUT;
                end
            endcase
        end
    end

    AST_READY_CLEAR: assert property (@(posedge clk) disable iff (rst)
        ready_o |-> !alert_o); // R7

    AST_CFG_HELD: assert property (@(posedge clk) disable iff (rst)
        (state_q != ST_LOAD) |=> $stable(cfg_o)); // R2

    AST_TRIAL_STEP: assert property (@(posedge clk) disable iff (rst)
        lfsr_step |=> trial_cnt_o == TRIAL_W'($past(trial_cnt_o) + 1'b1)); // R2

    AST_LOCKOUT_FROZEN: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_LOCKOUT) |=> (state_q == ST_LOCKOUT) && alert_o
                                    && $stable(cfg_o) && $stable(trial_cnt_o)); // R10

endmodule

// File: tb/entropy_tune_ctrl_tb_top.sv
module entropy_tune_ctrl_tb_top;

    typedef struct {
        string        tag;
        logic         ready;
        logic         alert;
        logic [9:0]   trial;
        logic [95:0]  cfg;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cnt_valid_i = 1'b0;
    logic [8:0]  cnt_i = '0;
    logic [12:0] batch_len_i = 13'd4;
    logic [8:0]  mean_lo_i = 9'd70;
    logic [8:0]  mean_hi_i = 9'd85;
    logic [8:0]  max_lo_i = 9'd60;
    logic [8:0]  max_hi_i = 9'd200;
    logic [9:0]  trial_limit_i = 10'd4;
    logic [95:0] cfg_o;
    logic        ready_o;
    logic        bits_valid_o;
    logic        alert_o;
    logic [9:0]  trial_cnt_o;

    int   n_checks = 0;
    int   n_fails  = 0;
    exp_t exp_q[$];
    event chk_ev;
    logic [95:0] words[0:9];

    always #5 clk = ~clk;

    entropy_tune_ctrl dut_i (
        .clk           (clk),
        .rst           (rst),
        .cnt_valid_i   (cnt_valid_i),
        .cnt_i         (cnt_i),
        .batch_len_i   (batch_len_i),
        .mean_lo_i     (mean_lo_i),
        .mean_hi_i     (mean_hi_i),
        .max_lo_i      (max_lo_i),
        .max_hi_i      (max_hi_i),
        .trial_limit_i (trial_limit_i),
        .cfg_o         (cfg_o),
        .ready_o       (ready_o),
        .bits_valid_o  (bits_valid_o),
        .alert_o       (alert_o),
        .trial_cnt_o   (trial_cnt_o)
    );

    function automatic logic [95:0] gen_next(logic [95:0] s);
        return {s[94:0], s[95] ^ s[93] ^ s[48] ^ s[46]};
    endfunction

    task automatic check_val(string tag, logic [127:0] act, logic [127:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    endtask

    // Monitor: pops the expected state and compares it with the outputs
    initial begin
        forever begin
            @(chk_ev);
            while (exp_q.size() > 0) begin
                exp_t e;
                e = exp_q.pop_front();
                check_val({e.tag, " ready"}, 128'(ready_o), 128'(e.ready));
                check_val({e.tag, " alert"}, 128'(alert_o), 128'(e.alert));
                check_val({e.tag, " trial"}, 128'(trial_cnt_o), 128'(e.trial));
                check_val({e.tag, " cfg"}, 128'(cfg_o), 128'(e.cfg));
            end
        end
    end

    task automatic expect_state(string tag, logic r, logic a, logic [9:0] t, logic [95:0] c);
        exp_t e;
        e.tag = tag; e.ready = r; e.alert = a; e.trial = t; e.cfg = c;
        exp_q.push_back(e);
        -> chk_ev;
        #1;
    endtask

    // Driver: one batch of four counts, then a settle gap
    task automatic send_batch(int v0, int v1, int v2, int v3, logic exp_bv, string tag);
        int vals[4];
        vals = '{v0, v1, v2, v3};
        foreach (vals[i]) begin
            @(negedge clk);
            cnt_valid_i = 1'b1;
            cnt_i       = 9'(vals[i]);
            if (i == 0) begin
                #1;
                check_val({tag, " R9 bits_valid"}, 128'(bits_valid_o), 128'(exp_bv));
            end
        end
        @(negedge clk);
        cnt_valid_i = 1'b0;
        repeat (5) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog actual=running expected=done");
        finish_run();
    end

    initial begin
        words[0] = 96'h5A5A_0000_0000_0000_0000_ACE1;
        for (int k = 1; k < 10; k++) words[k] = gen_next(words[k-1]);

        repeat (3) @(negedge clk);
        check_val("R1 reset ready", 128'(ready_o), 128'(0));
        check_val("R1 reset alert", 128'(alert_o), 128'(0));
        check_val("R1 reset trial", 128'(trial_cnt_o), 128'(0));
        check_val("R1 reset cfg", 128'(cfg_o), 128'(0));
        check_val("R1 reset bits_valid", 128'(bits_valid_o), 128'(0));
        rst = 1'b0;
        repeat (2) @(negedge clk);
        expect_state("R1 first trial seed", 1'b0, 1'b0, 10'd1, words[0]);

        send_batch(50, 50, 50, 50, 1'b0, "R4 low mean");
        expect_state("R4 low mean no alert, R2 next word", 1'b0, 1'b0, 10'd2, words[1]);

        send_batch(70, 70, 70, 70, 1'b0, "R4 lower edge");
        expect_state("R7 lock at lower edge", 1'b1, 1'b0, 10'd2, words[1]);

        send_batch(85, 85, 85, 85, 1'b1, "R8 upper edge monitor");
        expect_state("R8 lock kept at upper edge", 1'b1, 1'b0, 10'd2, words[1]);

        send_batch(86, 86, 86, 86, 1'b1, "R6 mean high monitor");
        expect_state("R6 R8 lock lost, restart", 1'b0, 1'b1, 10'd1, words[2]);
        @(negedge clk);
        cnt_valid_i = 1'b1;
        #1;
        check_val("R9 gate closed after loss", 128'(bits_valid_o), 128'(0));
        cnt_valid_i = 1'b0;

        send_batch(40, 40, 40, 201, 1'b0, "R5 max high");
        expect_state("R5 max out rejects", 1'b0, 1'b1, 10'd2, words[3]);

        send_batch(80, 80, 80, 80, 1'b0, "R7 good");
        expect_state("R7 lock clears alert", 1'b1, 1'b0, 10'd2, words[3]);

        send_batch(50, 50, 50, 50, 1'b1, "R8 low while locked");
        expect_state("R8 low mean while locked alerts", 1'b0, 1'b1, 10'd1, words[4]);

        send_batch(50, 50, 50, 50, 1'b0, "R10 search 2");
        expect_state("R10 trial 2", 1'b0, 1'b1, 10'd2, words[5]);
        send_batch(50, 50, 50, 50, 1'b0, "R10 search 3");
        expect_state("R10 trial 3", 1'b0, 1'b1, 10'd3, words[6]);
        send_batch(50, 50, 50, 50, 1'b0, "R10 search 4");
        expect_state("R10 trial 4", 1'b0, 1'b1, 10'd4, words[7]);
        send_batch(50, 50, 50, 50, 1'b0, "R10 exhaust");
        expect_state("R10 lockout", 1'b0, 1'b1, 10'd4, words[7]);
        send_batch(80, 80, 80, 80, 1'b0, "R10 ignored batch");
        expect_state("R10 lockout holds", 1'b0, 1'b1, 10'd4, words[7]);

        repeat (2) @(negedge clk);
        finish_run();
    end

endmodule